// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block decides which interrupt a small 8-bit processor core takes next. It watches five request sources: one non-maskable trap, a set of restart lines that software can mask one by one, and a general request line that has to be answered by an external acknowledge cycle. Requests are arbitrated only inside a sampling window. The window is open when the core pulses its strobe in the next-to-last clock of an instruction, and for as long as the core is halted or has handed the bus to another master.

When a request wins inside the window, the block registers a one-cycle take pulse together with a source code, a restart vector and a flag telling the core whether it must run an acknowledge cycle instead of jumping straight to the vector. Taking any interrupt clears the global enable. Software drives enable, disable and mask-write commands, and can poll a status word that shows the masks, the enable and every pending request.

The highest restart line and the trap are captured on rising edges and held until they are taken. The lower restart lines are plain levels. Instruction decode, the stack push and the acknowledge bus cycle belong to the core.

Top module: `irqp_ctrl`

## Requirements
- R1: A pending trap wins over every other request whatever the masks and the global enable are. It is reported as source code 1 with vector 0x24 and need_ack_o low.
- R2: A restart line is taken only while the global enable is set and its mask bit is clear. Line 2 ranks above line 1, and line 1 above line 0. They report source codes 2, 3 and 4 with vectors 0x3C, 0x34 and 0x2C.
- R3: Requests are arbitrated only at a clock edge where sample_i, halt_i or hold_i is high. take_o is high for exactly the one cycle that follows that edge, and stays low when there is no window.
- R4: After reset every mask bit is set, the global enable is clear, nothing is pending, status_o reads 0x07 and take_o is low. Any acceptance clears the global enable.
- R5: The general request is taken only when the enable is set and no trap or unmasked restart line is active. It reports source code 5, vector 0x00 and need_ack_o high. Trap and restart acceptances always give need_ack_o low.
- R6: Restart line 2 is captured on a rising edge and stays pending after the input drops. The capture is cleared when line 2 is taken, or when a mask write has bit 4 set.
- R7: Restart lines 1 and 0 are level-sensitive. A pulse that ends before the sampling edge is never taken.
- R8: On a mask write (mask_wr_i high), bits 2:0 of mask_wdata_i become the masks for lines 2..0 only when bit 3 is set. Without bit 3 the masks keep their value.
- R9: status_o carries the masks in bits 2:0 and the global enable in bit 3. Bits 6:4 show the pending state of lines 2..0 (the latched capture for line 2, the live level for lines 1 and 0). Bit 7 is the trap capture.
- R10: The trap is captured on its rising edge. One edge gives exactly one acceptance, even if the input stays high.
- R11: ei_i sets the global enable and di_i clears it. di_i wins when both are high, and an acceptance in the same cycle wins over ei_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 1 | Per-instruction sampling strobe from the core |
| halt_i | input | 1 | Core is halted; the sampling window is open |
| hold_i | input | 1 | Bus is granted away; the sampling window is open |
| ei_i | input | 1 | Set the global enable |
| di_i | input | 1 | Clear the global enable |
| mask_wr_i | input | 1 | Mask write command strobe |
| mask_wdata_i | input | 5 | [2:0] masks, [3] apply masks, [4] clear line 2 capture |
| trap_i | input | 1 | Non-maskable trap request |
| rst_i | input | 3 | Restart lines, bit 2 highest priority |
| intr_i | input | 1 | General request needing an acknowledge cycle |
| take_o | output | 1 | One-cycle pulse: an interrupt was accepted |
| src_o | output | 3 | Accepted source code (0 none) |
| vec_o | output | 8 | Restart vector of the accepted source |
| need_ack_o | output | 1 | Accepted source needs an external acknowledge cycle |
| status_o | output | 8 | Masks, enable and pending bits |

## Verification
The assertions check on every cycle that a take only follows an open window, that the enable is clear whenever a take is reported, that a maskable take was preceded by a set enable, and that the trap and restart outcomes carry their fixed vector and no acknowledge request. The ranking between simultaneous sources under every mask and enable setting, the edge capture and clearing of line 2 and the trap, the loss of short level pulses, and the mask-write field decoding can only be shown by the bench's scenarios. Those scenarios include a sweep over all request, mask and enable combinations.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
    localparam int IRQP_NRST     = 3;
    localparam int IRQP_VEC_W    = 8;
    localparam int IRQP_VEC_BASE = 36;
    localparam int IRQP_VEC_STEP = 8;

    localparam int SRC_NONE = 0;
    localparam int SRC_TRAP = 1;

    // Code of restart line i (highest line gets the smallest code after trap)
    function automatic int line_code(input int i, input int n);
        return 2 + (n - 1 - i);
    endfunction

    function automatic int gen_code(input int n);
        return n + 2;
    endfunction
endpackage

// File: rtl/irqp_edge_latch.sv
module irqp_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic clr_i,
    output logic pend_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } el_t;

    el_t el_d, el_q;

    always_comb begin
        el_d.prev = req_i;
        // a fresh edge wins over a clear in the same cycle
        el_d.pend = (req_i & ~el_q.prev) | (el_q.pend & ~clr_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) el_q <= '0;
        else        el_q <= el_d;
    end

    assign pend_o = el_q.pend;
endmodule

// File: rtl/irqp_arbiter.sv
module irqp_arbiter
    import irqp_pkg::*;
#(
    parameter int NUM_RST  = IRQP_NRST,
    parameter int SRC_W    = 3,
    parameter int VEC_W    = IRQP_VEC_W,
    parameter int VEC_BASE = IRQP_VEC_BASE,
    parameter int VEC_STEP = IRQP_VEC_STEP
) (
    input  logic               trap_pend_i,
    input  logic [NUM_RST-1:0] line_req_i,
    input  logic [NUM_RST-1:0] mask_i,
    input  logic               ie_i,
    input  logic               gen_req_i,
    output logic               hit_o,
    output logic [SRC_W-1:0]   src_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic               need_ack_o
);
    logic [NUM_RST-1:0] live;

    always_comb begin
        live       = line_req_i & ~mask_i & {NUM_RST{ie_i}};
        hit_o      = 1'b0;
        src_o      = SRC_W'(SRC_NONE);
        vec_o      = '0;
        need_ack_o = 1'b0;
        if (trap_pend_i) begin
            hit_o = 1'b1;
            src_o = SRC_W'(SRC_TRAP);
            vec_o = VEC_W'(VEC_BASE);
        end else if (|live) begin
            hit_o = 1'b1;
            // ascending scan: the highest live line is assigned last and wins
            for (int i = 0; i < NUM_RST; i++) begin
                if (live[i]) begin
                    src_o = SRC_W'(line_code(i, NUM_RST));
                    vec_o = VEC_W'(VEC_BASE + VEC_STEP * (i + 1));
                end
            end
        end else if (ie_i && gen_req_i) begin
            hit_o      = 1'b1;
            src_o      = SRC_W'(gen_code(NUM_RST));
            need_ack_o = 1'b1;
        end
    end
endmodule

// File: rtl/irqp_ctrl.sv
module irqp_ctrl
    import irqp_pkg::*;
#(
    parameter int NUM_RST  = IRQP_NRST,
    parameter int VEC_W    = IRQP_VEC_W,
    parameter int VEC_BASE = IRQP_VEC_BASE,
    parameter int VEC_STEP = IRQP_VEC_STEP,
    localparam int SRC_W   = $clog2(NUM_RST + 3),
    localparam int CMD_W   = NUM_RST + 2,
    localparam int STAT_W  = 2 * NUM_RST + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_i,
    input  logic               halt_i,
    input  logic               hold_i,
    input  logic               ei_i,
    input  logic               di_i,
    input  logic               mask_wr_i,
    input  logic [CMD_W-1:0]   mask_wdata_i,
    input  logic               trap_i,
    input  logic [NUM_RST-1:0] rst_i,
    input  logic               intr_i,
    output logic               take_o,
    output logic [SRC_W-1:0]   src_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic               need_ack_o,
    output logic [STAT_W-1:0]  status_o
);
    localparam int TOP      = NUM_RST - 1;
    localparam int APPLY_B  = NUM_RST;
    localparam int CLRTOP_B = NUM_RST + 1;

    typedef struct packed {
        logic [NUM_RST-1:0] mask;
        logic               ie;
        logic               take;
        logic [SRC_W-1:0]   src;
        logic [VEC_W-1:0]   vec;
        logic               need_ack;
    } state_t;

    state_t st_d, st_q;

    logic               win;
    logic               accept;
    logic               trap_pend;
    logic               clr_trap;
    logic               clr_top;
    logic [NUM_RST-1:0] line_req;
    logic               arb_hit;
    logic [SRC_W-1:0]   arb_src;
    logic [VEC_W-1:0]   arb_vec;
    logic               arb_ack;

    assign win    = sample_i | halt_i | hold_i;
    assign accept = win & arb_hit;

    assign clr_trap = accept && (arb_src == SRC_W'(SRC_TRAP));
    assign clr_top  = (accept && (arb_src == SRC_W'(line_code(TOP, NUM_RST))))
                   || (mask_wr_i && mask_wdata_i[CLRTOP_B]);

    irqp_edge_latch u_trap_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (trap_i),
        .clr_i  (clr_trap),
        .pend_o (trap_pend)
    );

    // Top restart line is edge captured, the others pass their level through
    for (genvar g = 0; g < NUM_RST; g++) begin : g_line
        if (g == TOP) begin : g_edge
            irqp_edge_latch u_latch (
                .clk    (clk),
                .rst_n  (rst_n),
                .req_i  (rst_i[g]),
                .clr_i  (clr_top),
                .pend_o (line_req[g])
            );
        end else begin : g_level
            assign line_req[g] = rst_i[g];
        end
    end

    irqp_arbiter #(
        .NUM_RST  (NUM_RST),
        .SRC_W    (SRC_W),
        .VEC_W    (VEC_W),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_arb (
        .trap_pend_i (trap_pend),
        .line_req_i  (line_req),
        .mask_i      (st_q.mask),
        .ie_i        (st_q.ie),
        .gen_req_i   (intr_i),
        .hit_o       (arb_hit),
        .src_o       (arb_src),
        .vec_o       (arb_vec),
        .need_ack_o  (arb_ack)
    );

    always_comb begin
        st_d = st_q;
        if (mask_wr_i && mask_wdata_i[APPLY_B]) begin
            st_d.mask = mask_wdata_i[NUM_RST-1:0];
        end
        if (accept)     st_d.ie = 1'b0;
        else if (di_i)  st_d.ie = 1'b0;
        else if (ei_i)  st_d.ie = 1'b1;
        st_d.take     = accept;
        st_d.src      = accept ? arb_src : SRC_W'(SRC_NONE);
        st_d.vec      = accept ? arb_vec : '0;
        st_d.need_ack = accept & arb_ack;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_o     = st_q.take;
    assign src_o      = st_q.src;
    assign vec_o      = st_q.vec;
    assign need_ack_o = st_q.need_ack;
    assign status_o   = {trap_pend, line_req, st_q.ie, st_q.mask};

    // R3: a take is only reported after an open sampling window
    p_take_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(win));

    // R4: the enable is already clear when a take is reported
    p_ie_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !status_o[NUM_RST]);

    // R2: a maskable take needs the enable in the sampling cycle
    p_maskable_needs_ie_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && src_o != SRC_W'(SRC_TRAP)) |-> $past(st_q.ie));

    // R5: only the general request asks for an acknowledge cycle
    p_no_ack_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && src_o != SRC_W'(gen_code(NUM_RST))) |-> !need_ack_o);

    // R1: the trap always reports the base vector
    p_trap_vector_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && src_o == SRC_W'(SRC_TRAP)) |-> (vec_o == VEC_W'(VEC_BASE)));
endmodule

// File: tb/irqp_ctrl_bench.sv
module irqp_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_i = 0, halt_i = 0, hold_i = 0, ei_i = 0, di_i = 0;
    logic       mask_wr_i = 0;
    logic [4:0] mask_wdata_i = '0;
    logic       trap_i = 0, intr_i = 0;
    logic [2:0] rst_i = '0;
    logic       take_o, need_ack_o;
    logic [2:0] src_o;
    logic [7:0] vec_o, status_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irqp_ctrl u_irqp_ctrl (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .halt_i(halt_i),
        .hold_i(hold_i), .ei_i(ei_i), .di_i(di_i), .mask_wr_i(mask_wr_i),
        .mask_wdata_i(mask_wdata_i), .trap_i(trap_i), .rst_i(rst_i),
        .intr_i(intr_i), .take_o(take_o), .src_o(src_o), .vec_o(vec_o),
        .need_ack_o(need_ack_o), .status_o(status_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; sample_i = 0; halt_i = 0; hold_i = 0; ei_i = 0; di_i = 0;
        mask_wr_i = 0; mask_wdata_i = '0; trap_i = 0; rst_i = '0; intr_i = 0;
        step(); step();
        rst_n = 1;
        step();
    endtask

    task automatic setup(input logic [2:0] m, input bit en);
        mask_wr_i = 1; mask_wdata_i = {2'b01, m}; ei_i = en;
        step();
        mask_wr_i = 0; mask_wdata_i = '0; ei_i = 0;
    endtask

    task automatic sample_once();
        sample_i = 1; step(); sample_i = 0;
    endtask

    initial begin
        step();
        do_reset();
        chk("R4 reset status", status_o, 8'h07);
        chk("R4 reset take", take_o, 0);

        // Sweep: every request pattern x mask x enable
        for (int en = 0; en < 2; en++) begin
            for (int m = 0; m < 8; m++) begin
                for (int p = 0; p < 32; p++) begin
                    logic tr, gi;
                    logic [2:0] rl;
                    int es, ev, ea, et;
                    tr = p[4]; rl = p[3:1]; gi = p[0];
                    et = 1; es = 0; ev = 0; ea = 0;
                    if (tr) begin es = 1; ev = 36; end
                    else if (en == 1 && (rl & ~m[2:0]) != 0) begin
                        for (int k = 0; k < 3; k++)
                            if (rl[k] && !m[k]) begin es = 2 + (2 - k); ev = 36 + 8 * (k + 1); end
                    end else if (en == 1 && gi) begin es = 5; ev = 0; ea = 1; end
                    else et = 0;
                    do_reset();
                    setup(m[2:0], en[0]);
                    chk("R8 mask applied", status_o[2:0], m[2:0]);
                    trap_i = tr; rst_i = rl; intr_i = gi;
                    step();
                    sample_once();
                    chk("R1/R2/R5 take", take_o, et);
                    chk("R1/R2/R5 source", src_o, es);
                    chk("R1/R2/R5 vector", vec_o, ev);
                    chk("R5 need_ack", need_ack_o, ea);
                    chk("R4 enable after sample", status_o[3], (et == 1) ? 0 : en);
                    chk("R9 line2 pending", status_o[6], (es == 2) ? 0 : rl[2]);
                    chk("R9 trap pending", status_o[7], 0);
                    chk("R9 level lines", status_o[5:4], rl[1:0]);
                    trap_i = 0; rst_i = '0; intr_i = 0;
                end
            end
        end

        // R3: no window, no take; halt and hold open the window
        do_reset(); setup(3'b000, 1);
        rst_i = 3'b001;
        for (int i = 0; i < 3; i++) begin step(); chk("R3 no window", take_o, 0); end
        halt_i = 1; step(); halt_i = 0;
        chk("R3 halt window take", take_o, 1);
        chk("R3 halt window source", src_o, 4);
        step();
        chk("R3 single cycle pulse", take_o, 0);
        do_reset(); setup(3'b000, 1);
        rst_i = 3'b010; hold_i = 1; step(); hold_i = 0;
        chk("R3 hold window source", src_o, 3);

        // R6: line 2 pulse is captured and later taken
        do_reset(); setup(3'b000, 1);
        rst_i = 3'b100; step(); rst_i = 3'b000; step(); step();
        chk("R6 captured", status_o[6], 1);
        sample_once();
        chk("R6 taken source", src_o, 2);
        chk("R6 taken vector", vec_o, 8'h3C);
        chk("R6 cleared on take", status_o[6], 0);

        // R6/R8: clear bit without apply bit
        do_reset(); setup(3'b000, 1);
        rst_i = 3'b100; step(); rst_i = 3'b000; step();
        mask_wr_i = 1; mask_wdata_i = 5'b10111; step(); mask_wr_i = 0; mask_wdata_i = '0;
        chk("R6 cleared by command", status_o[6], 0);
        chk("R8 masks kept without apply", status_o[2:0], 3'b000);
        sample_once();
        chk("R6 cleared not taken", take_o, 0);
        mask_wr_i = 1; mask_wdata_i = 5'b01101; step(); mask_wr_i = 0;
        chk("R8 masks written", status_o[2:0], 3'b101);

        // R7: short level pulse on line 1 is lost
        do_reset(); setup(3'b000, 1);
        rst_i = 3'b010; step(); rst_i = 3'b000; step();
        sample_once();
        chk("R7 level pulse lost", take_o, 0);

        // R10: held trap gives one acceptance
        do_reset();
        trap_i = 1; step();
        chk("R10 trap captured", status_o[7], 1);
        sample_once();
        chk("R10 first take", src_o, 1);
        ei_i = 1; step(); ei_i = 0;
        sample_once();
        chk("R10 no second take", take_o, 0);
        chk("R10 trap pending clear", status_o[7], 0);
        trap_i = 0;

        // R11: enable command precedence
        do_reset();
        ei_i = 1; di_i = 1; step(); ei_i = 0; di_i = 0;
        chk("R11 di wins", status_o[3], 0);
        ei_i = 1; step(); ei_i = 0;
        chk("R11 ei sets", status_o[3], 1);
        mask_wr_i = 1; mask_wdata_i = 5'b01000; step(); mask_wr_i = 0;
        rst_i = 3'b001; sample_i = 1; ei_i = 1; step(); sample_i = 0; ei_i = 0; rst_i = 0;
        chk("R11 take with ei", take_o, 1);
        chk("R11 accept beats ei", status_o[3], 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule